// File: doc/BRIEF.md
# Control Transfer Phase Sequencer

This block follows the phase of each control transfer on endpoint zero of a USB device controller. It sits next to the endpoint-zero status register and reacts to each endpoint-zero interrupt. When a SETUP packet arrives it decodes the direction and the length of the data stage. It then moves to an idle, transmit (IN data stage) or receive (OUT data stage) phase, and it keeps count of the bytes still to be moved.

On each later interrupt it takes in the byte count of the packet that just moved. It then asks for one of three things, each as a one-cycle request pulse: load another transmit packet, write the data-end bit, or write the serviced-receive-ready bit. A stall or an early end of the control transfer cancels the current transfer. The block does not move FIFO data, build descriptors or hold register contents. Its caller turns each request pulse into the matching register write.

Top module: `ctl_phase_seq`

## Requirements
- R1: After reset the phase is idle (encoding 0), the remaining count is 0 and every request pulse is low.
- R2: On an interrupt with the stall flag or the early-end flag set, the block does the same whatever the phase, receive flag or packet count. In the next cycle the phase is idle and the remaining count is 0. `xfer_abort` pulses and no data-end request is raised.
- R3: An interrupt in the idle phase with the receive flag clear has no effect: the phase and the count do not change and no pulse is raised.
- R4: A SETUP packet is a 64-bit vector with byte k at bits 8k+7..8k. Its length is byte 6 (low) and byte 7 (high). A length of 0 leaves the phase idle with a count of 0 and raises no pulse.
- R5: A SETUP packet with a nonzero length and bit 7 of byte 0 set enters the transmit phase (encoding 1) with the count set to the length, and `req_more_data` pulses. If that bit is clear, the block enters the receive phase (encoding 2) with the count set to the length and raises no pulse.
- R6: In the transmit phase, a full packet (byte count equal to MAX_PKT) that leaves bytes still due raises `req_more_data`. The block stays in the transmit phase with the count reduced by the packet size.
- R7: In the transmit phase, a short packet (fewer than MAX_PKT bytes), or a packet that brings the count to 0, raises `req_data_end`. The phase returns to idle with a count of 0.
- R8: In the receive phase, a packet that leaves bytes still due raises `req_rx_serviced`. The block stays in the receive phase with the count reduced by the packet size.
- R9: In the receive phase, a packet that brings the count to 0 raises `req_data_end`. The phase returns to idle.
- R10: The count is reduced by the smaller of the packet size and the count, so it never wraps below 0.
- R11: Request pulses appear only in the cycle after an interrupt and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep0_irq | input | 1 | Endpoint-zero interrupt event, one cycle per event |
| stall_sent | input | 1 | Stall-sent status flag |
| setup_ended | input | 1 | Early end of control transfer status flag |
| rx_ready | input | 1 | Receive-packet-ready status flag |
| setup_pkt | input | 64 | Eight SETUP bytes, byte k at bits 8k+7..8k |
| pkt_bytes | input | $clog2(MAX_PKT+1) | Byte count of the packet just sent or received |
| phase | output | 2 | Current phase: 0 idle, 1 transmit, 2 receive |
| remain | output | 16 | Bytes still due in the data stage |
| req_data_end | output | 1 | Pulse: write the data-end bit |
| req_rx_serviced | output | 1 | Pulse: write the serviced-receive-ready bit |
| req_more_data | output | 1 | Pulse: load another transmit packet |
| xfer_abort | output | 1 | Pulse: transfer cancelled by stall or early end |

## Verification
The bench builds the block with MAX_PKT set to 8, which makes the transmit and receive data stages span several packets with lengths of only a few tens of bytes. This covers both ways a transmit stage can end (short packet, and exact exhaustion on a full packet) and an overrunning last receive packet that must clamp at zero. A SETUP length of 0x0102 checks that the high length byte lands in the upper half of the count. Aborts are driven in both data phases, including one where a short packet arrives in the same cycle as the stall flag.

// File: rtl/ctl_phase_pkg.sv
package ctl_phase_pkg;

   localparam int SETUP_BYTES = 8;
   localparam int SETUP_LEN_W = 16;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_TX   = 2'd1,
      PH_RX   = 2'd2
   } phase_e;

   typedef struct packed {
      logic                   dir_in;
      logic                   has_data;
      logic [SETUP_LEN_W-1:0] len;
   } setup_info_t;

endpackage

// File: rtl/ctl_setup_decode.sv
module ctl_setup_decode
   import ctl_phase_pkg::*;
#(
   parameter int NUM_BYTES  = SETUP_BYTES,
   parameter int DIR_BIT    = 7,
   parameter int LEN_LO_IDX = 6
) (
   input  logic [NUM_BYTES*8-1:0] pkt,
   output setup_info_t            info
);

   localparam int LEN_HI_IDX = LEN_LO_IDX + 1;

   if (LEN_HI_IDX >= NUM_BYTES) begin : g_bad_len_idx
      $error("length field lies outside the SETUP packet");
   end
   if (DIR_BIT > 7) begin : g_bad_dir_bit
      $error("direction bit must be within a byte");
   end

   logic [7:0] len_lo;
   logic [7:0] len_hi;

   assign len_lo = pkt[LEN_LO_IDX*8 +: 8];
   assign len_hi = pkt[LEN_HI_IDX*8 +: 8];

   assign info.len      = {len_hi, len_lo};
   assign info.dir_in   = pkt[DIR_BIT];
   assign info.has_data = (info.len != '0);

   logic unused_setup_bits;
   assign unused_setup_bits = ^pkt;

endmodule

// File: rtl/ctl_len_track.sv
module ctl_len_track #(
   parameter int LEN_W = 16,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   input  logic [CNT_W-1:0] dec_val,
   output logic [LEN_W-1:0] cnt,
   output logic             will_empty
);

   if (CNT_W > LEN_W) begin : g_bad_width
      $error("packet count wider than length counter");
   end

   logic [LEN_W-1:0] dec_ext;
   logic [LEN_W-1:0] step;
   logic [LEN_W-1:0] after_dec;

   if (LEN_W > CNT_W) begin : g_zext
      assign dec_ext = {{(LEN_W-CNT_W){1'b0}}, dec_val};
   end else begin : g_same
      assign dec_ext = dec_val;
   end

   assign step       = (dec_ext > cnt) ? cnt : dec_ext;
   assign after_dec  = cnt - step;
   assign will_empty = (after_dec == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec) begin
         cnt <= after_dec;
      end
   end

   assert_no_wrap_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !clear) |=> (cnt <= $past(cnt)));

   assert_clear_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/ctl_phase_fsm.sv
module ctl_phase_fsm
   import ctl_phase_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq,
   input  logic             stall,
   input  logic             early_end,
   input  logic             rx_ready,
   input  setup_info_t      info,
   input  logic [CNT_W-1:0] pkt_bytes,
   input  logic             will_empty,
   output phase_e           phase,
   output logic             trk_clear,
   output logic             trk_load,
   output logic             trk_dec,
   output logic             p_data_end,
   output logic             p_rx_serv,
   output logic             p_more,
   output logic             p_abort
);

   if (MAX_PKT < 1) begin : g_bad_pkt
      $error("MAX_PKT must be positive");
   end

   localparam logic [CNT_W-1:0] FULL_PKT = CNT_W'(MAX_PKT);

   phase_e nxt_phase;
   logic   n_end, n_serv, n_more, n_abort;
   logic   short_pkt;
   logic   err;

   assign err       = stall | early_end;
   assign short_pkt = (pkt_bytes < FULL_PKT);

   always_comb begin
      nxt_phase = phase;
      trk_clear = 1'b0;
      trk_load  = 1'b0;
      trk_dec   = 1'b0;
      n_end     = 1'b0;
      n_serv    = 1'b0;
      n_more    = 1'b0;
      n_abort   = 1'b0;
      if (irq) begin
         if (err) begin
            nxt_phase = PH_IDLE;
            trk_clear = 1'b1;
            n_abort   = 1'b1;
         end else begin
            unique case (phase)
               PH_IDLE: begin
                  if (rx_ready) begin
                     trk_load = 1'b1;
                     if (info.has_data) begin
                        nxt_phase = info.dir_in ? PH_TX : PH_RX;
                        n_more    = info.dir_in;
                     end
                  end
               end
               PH_TX: begin
                  trk_dec = 1'b1;
                  if (short_pkt || will_empty) begin
                     n_end     = 1'b1;
                     trk_clear = 1'b1;
                     nxt_phase = PH_IDLE;
                  end else begin
                     n_more = 1'b1;
                  end
               end
               PH_RX: begin
                  trk_dec = 1'b1;
                  if (will_empty) begin
                     n_end     = 1'b1;
                     trk_clear = 1'b1;
                     nxt_phase = PH_IDLE;
                  end else begin
                     n_serv = 1'b1;
                  end
               end
               default: begin
                  nxt_phase = PH_IDLE;
                  trk_clear = 1'b1;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         p_data_end <= 1'b0;
         p_rx_serv  <= 1'b0;
         p_more     <= 1'b0;
         p_abort    <= 1'b0;
      end else begin
         phase      <= nxt_phase;
         p_data_end <= n_end;
         p_rx_serv  <= n_serv;
         p_more     <= n_more;
         p_abort    <= n_abort;
      end
   end

   assert_abort_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && err) |=> (phase == PH_IDLE && !p_data_end && p_abort));

   assert_idle_noise_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !err && phase == PH_IDLE && !rx_ready) |=> (phase == PH_IDLE && !p_more));

   assert_tx_entry_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !err && phase == PH_IDLE && rx_ready && info.has_data && info.dir_in)
      |=> (phase == PH_TX && p_more));

   assert_one_request_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones({p_data_end, p_rx_serv, p_more, p_abort}) <= 1);

   assert_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !irq |=> !(p_data_end || p_rx_serv || p_more || p_abort));

endmodule

// File: rtl/ctl_phase_seq.sv
module ctl_phase_seq
   import ctl_phase_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ep0_irq,
   input  logic                     stall_sent,
   input  logic                     setup_ended,
   input  logic                     rx_ready,
   input  logic [SETUP_BYTES*8-1:0] setup_pkt,
   input  logic [CNT_W-1:0]         pkt_bytes,
   output logic [1:0]               phase,
   output logic [SETUP_LEN_W-1:0]   remain,
   output logic                     req_data_end,
   output logic                     req_rx_serviced,
   output logic                     req_more_data,
   output logic                     xfer_abort
);

   setup_info_t info;
   phase_e      cur_phase;
   logic        trk_clear, trk_load, trk_dec, will_empty;

   ctl_setup_decode #(
      .NUM_BYTES (SETUP_BYTES),
      .DIR_BIT   (7),
      .LEN_LO_IDX(6)
   ) u_decode (
      .pkt (setup_pkt),
      .info(info)
   );

   ctl_len_track #(
      .LEN_W(SETUP_LEN_W),
      .CNT_W(CNT_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (trk_clear),
      .load      (trk_load),
      .load_val  (info.len),
      .dec       (trk_dec),
      .dec_val   (pkt_bytes),
      .cnt       (remain),
      .will_empty(will_empty)
   );

   ctl_phase_fsm #(
      .MAX_PKT(MAX_PKT),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (ep0_irq),
      .stall     (stall_sent),
      .early_end (setup_ended),
      .rx_ready  (rx_ready),
      .info      (info),
      .pkt_bytes (pkt_bytes),
      .will_empty(will_empty),
      .phase     (cur_phase),
      .trk_clear (trk_clear),
      .trk_load  (trk_load),
      .trk_dec   (trk_dec),
      .p_data_end(req_data_end),
      .p_rx_serv (req_rx_serviced),
      .p_more    (req_more_data),
      .p_abort   (xfer_abort)
   );

   assign phase = cur_phase;

   assert_idle_empty_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      req_data_end |-> (phase == 2'd0 && remain == '0));

   assert_abort_count_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort |-> (remain == '0 && phase == 2'd0));

   assert_rx_stays_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      req_rx_serviced |-> (phase == 2'd2 && remain != '0));

endmodule

// File: tb/test_ctl_phase_seq.sv
module test_ctl_phase_seq;

   localparam int BMAX = 8;
   localparam int BCW  = $clog2(BMAX + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ep0_irq = 1'b0;
   logic           stall_sent = 1'b0;
   logic           setup_ended = 1'b0;
   logic           rx_ready = 1'b0;
   logic [63:0]    setup_pkt = '0;
   logic [BCW-1:0] pkt_bytes = '0;
   logic [1:0]     phase;
   logic [15:0]    remain;
   logic           req_data_end, req_rx_serviced, req_more_data, xfer_abort;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   ctl_phase_seq #(.MAX_PKT(BMAX)) i_ctl_phase_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .ep0_irq        (ep0_irq),
      .stall_sent     (stall_sent),
      .setup_ended    (setup_ended),
      .rx_ready       (rx_ready),
      .setup_pkt      (setup_pkt),
      .pkt_bytes      (pkt_bytes),
      .phase          (phase),
      .remain         (remain),
      .req_data_end   (req_data_end),
      .req_rx_serviced(req_rx_serviced),
      .req_more_data  (req_more_data),
      .xfer_abort     (xfer_abort)
   );

   function automatic logic [63:0] mk_setup(input bit dir_in, input logic [15:0] len);
      return {len[15:8], len[7:0], 40'hA5_5A_3C_C3_11, dir_in ? 8'h86 : 8'h06};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // pulse vector order: {abort, more, serviced, data_end}
   task automatic expect_state(input string req, input logic [1:0] ph,
                               input logic [15:0] rem, input logic [3:0] pulses);
      chk({req, " phase"}, 32'(phase), 32'(ph));
      chk({req, " remain"}, 32'(remain), 32'(rem));
      chk({req, " pulses"}, 32'({xfer_abort, req_more_data, req_rx_serviced, req_data_end}),
          32'(pulses));
   endtask

   task automatic fire(input bit st, input bit se, input bit rr,
                       input logic [63:0] sp, input int nb);
      @(negedge clk);
      ep0_irq     = 1'b1;
      stall_sent  = st;
      setup_ended = se;
      rx_ready    = rr;
      setup_pkt   = sp;
      pkt_bytes   = BCW'(nb);
      @(negedge clk);
      ep0_irq     = 1'b0;
      stall_sent  = 1'b0;
      setup_ended = 1'b0;
      rx_ready    = 1'b0;
   endtask

   task automatic t_reset();
      expect_state("R1", 2'd0, 16'd0, 4'b0000);
   endtask

   task automatic t_idle_noise();
      fire(0, 0, 0, mk_setup(1, 16'd30), 5);
      expect_state("R3", 2'd0, 16'd0, 4'b0000);
   endtask

   task automatic t_zero_len();
      fire(0, 0, 1, mk_setup(1, 16'd0), 0);
      expect_state("R4 zero", 2'd0, 16'd0, 4'b0000);
   endtask

   task automatic t_tx_short_end();
      fire(0, 0, 1, mk_setup(1, 16'd20), 0);
      expect_state("R5 tx", 2'd1, 16'd20, 4'b0100);
      fire(0, 0, 0, '0, 8);
      expect_state("R6 a", 2'd1, 16'd12, 4'b0100);
      fire(0, 0, 0, '0, 8);
      expect_state("R6 b", 2'd1, 16'd4, 4'b0100);
      fire(0, 0, 0, '0, 4);
      expect_state("R7 short", 2'd0, 16'd0, 4'b0001);
   endtask

   task automatic t_tx_exact_end();
      fire(0, 0, 1, mk_setup(1, 16'd16), 0);
      fire(0, 0, 0, '0, 8);
      expect_state("R6 c", 2'd1, 16'd8, 4'b0100);
      fire(0, 0, 0, '0, 8);
      expect_state("R7 exact", 2'd0, 16'd0, 4'b0001);
   endtask

   task automatic t_rx_abort();
      fire(0, 0, 1, mk_setup(0, 16'h0102), 0);
      expect_state("R4 R5 rx hi byte", 2'd2, 16'h0102, 4'b0000);
      fire(0, 1, 1, '0, 3);
      expect_state("R2 early end", 2'd0, 16'd0, 4'b1000);
   endtask

   task automatic t_rx_overrun();
      fire(0, 0, 1, mk_setup(0, 16'd10), 0);
      fire(0, 0, 0, '0, 8);
      expect_state("R8", 2'd2, 16'd2, 4'b0010);
      fire(0, 0, 0, '0, 8);
      expect_state("R9 R10 clamp", 2'd0, 16'd0, 4'b0001);
   endtask

   task automatic t_tx_stall();
      fire(0, 0, 1, mk_setup(1, 16'd20), 0);
      fire(1, 0, 0, '0, 3);
      expect_state("R2 stall", 2'd0, 16'd0, 4'b1000);
   endtask

   task automatic t_quiet();
      fire(0, 0, 1, mk_setup(0, 16'd3), 0);
      fire(0, 0, 0, '0, 3);
      expect_state("R9 exact", 2'd0, 16'd0, 4'b0001);
      @(negedge clk);
      expect_state("R11", 2'd0, 16'd0, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_noise();
      t_zero_len();
      t_tx_short_end();
      t_tx_exact_end();
      t_rx_abort();
      t_rx_overrun();
      t_tx_stall();
      t_quiet();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule